// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address on a machine with 512-byte pages. The top two address bits pick a region. Three regions are usable: system space and two process regions. Each region is described by a base and a length value, supplied on input ports. The block checks the page number against the region's length and forms the address of the page table entry. It then fetches that entry with a single longword read on a simple request/data memory port. It either returns the physical address together with the entry's protection code, or it returns a fault code.

The process page tables are themselves located in system virtual space. A process translation therefore first translates the address of the process entry through the system table, then fetches the process entry from the physical address that results. Region 1 grows downward, so its length value counts the entries that do not exist at the low end of the table, and its length check is the reverse of the others. When translation is switched off, the physical address is the low 30 bits of the virtual address, and no memory read is made.

Requests arrive on a valid/ready handshake, one at a time. The result appears as a one-cycle response pulse.

Top module: `pgx_translator`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: With `map_enable` at 0 when a request is accepted, the response carries `rsp_paddr` = vaddr[29:0] and `rsp_fault` = 0. It arrives on the first clock after acceptance, and no memory read is made.
- R3: The region is decoded from vaddr[31:30]: 2 is system space, 0 is process region 0, 1 is process region 1. The value 3 produces `rsp_fault` = 3 (bad region), with `rsp_nested` = 0 and no memory read.
- R4: The page number is vaddr[29:9]. In system space and in region 0, a page number greater than or equal to the length value gives `rsp_fault` = 1 (length violation) with no memory read. Page numbers below the length value are allowed.
- R5: In region 1, a page number below `p1_len` gives `rsp_fault` = 1. A page number equal to `p1_len` or above it is allowed.
- R6: For system space, the entry is read from physical address `sys_base` + 4 × page number.
- R7: For process addresses, the entry's system virtual address is base + 4 × page number, modulo 2^32. That address is translated through the system table. If it is not in system space, the result is fault 3. If its page is out of the system length, the result is fault 1. If its system entry is invalid, the result is fault 2. Each of these faults reports `rsp_nested` = 1. Otherwise the process entry is read from {system entry[20:0], system virtual address[8:0]}.
- R8: A final entry with bit 31 clear gives `rsp_fault` = 2 (not valid) with `rsp_nested` = 0.
- R9: A valid final entry gives `rsp_paddr` = {entry[20:0], vaddr[8:0]}, `rsp_prot` = entry[30:27] and `rsp_fault` = 0.
- R10: Only one translation is in flight at a time. `req_ready` is 0 from acceptance until the response cycle, and `rsp_valid` lasts exactly one cycle. A system-space translation responds 3 clocks after acceptance and a full process translation responds 5 clocks after acceptance, when memory returns data one clock after each request.
- R11: `mem_req` is a one-cycle pulse. The block waits for `mem_rvalid` before it acts on `mem_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| map_enable | input | 1 | 1 translates, 0 passes the address through |
| sys_base | input | PA_W | Physical address of the system table |
| sys_len | input | LEN_W | Number of system table entries |
| p0_base | input | 32 | System virtual address of the region-0 table |
| p0_len | input | LEN_W | Number of region-0 table entries |
| p1_base | input | 32 | System virtual address of the entry for page 0 of region 1 |
| p1_len | input | LEN_W | Number of missing low region-1 entries |
| mem_req | output | 1 | Longword read request pulse |
| mem_addr | output | PA_W | Physical byte address of the read |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | PA_W | Translated physical address |
| rsp_fault | output | 2 | 0 none, 1 length, 2 not valid, 3 bad region |
| rsp_nested | output | 1 | Fault raised during the system lookup of a process entry |
| rsp_prot | output | 4 | Protection code of the final entry |

## Verification
The hardest cases to reach are the faults inside the nested lookup. A process request must be valid in its own region, yet the table address it points at must fail: it may lie outside system space, lie beyond the system length, or hit an invalid system entry. The stimulus reaches each of these by moving the region-0 base between otherwise identical requests. Region-1 boundary pages are reached by placing its base so that the first accessible page lands on a valid system page. The bench model predicts the response cycle and the number of memory reads from the stored tables, and compares the response on every clock.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 9;
  localparam int VPN_W  = 21;
  localparam int PROT_W = 4;
  localparam int PROT_HI = 30;
  localparam int VBIT   = 31;

  typedef enum logic [1:0] {
    RG_P0  = 2'd0,
    RG_P1  = 2'd1,
    RG_SYS = 2'd2,
    RG_BAD = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    FC_NONE     = 2'd0,
    FC_LENGTH   = 2'd1,
    FC_NOTVALID = 2'd2,
    FC_REGION   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLASS = 2'd1,
    ST_WSYS  = 2'd2,
    ST_WLEAF = 2'd3
  } walk_e;
endpackage

// File: rtl/pgx_region_check.sv
module pgx_region_check
  import pgx_pkg::*;
#(
  parameter int PA_W     = 30,
  parameter int LEN_W    = 22,
  parameter bit SYS_ONLY = 1'b0
) (
  input  logic [VA_W-1:0]  va,
  input  logic [PA_W-1:0]  sys_base,
  input  logic [LEN_W-1:0] sys_len,
  input  logic [VA_W-1:0]  p0_base,
  input  logic [LEN_W-1:0] p0_len,
  input  logic [VA_W-1:0]  p1_base,
  input  logic [LEN_W-1:0] p1_len,
  output region_e          region,
  output fault_e           fcode,
  output logic [VA_W-1:0]  tab_addr
);
  localparam int EXT_W = LEN_W - VPN_W;

  logic [VPN_W-1:0] vpn;
  logic [LEN_W-1:0] vpn_ext;
  logic [VA_W-1:0]  vpn_bytes;
  logic [VA_W-1:0]  sys_base_ext;

  assign vpn          = va[OFF_W+VPN_W-1:OFF_W];
  assign vpn_ext      = {{EXT_W{1'b0}}, vpn};
  assign vpn_bytes    = {{(VA_W-VPN_W-2){1'b0}}, vpn, 2'b00};
  assign sys_base_ext = {{(VA_W-PA_W){1'b0}}, sys_base};

  always_comb begin
    region   = RG_BAD;
    fcode    = FC_REGION;
    tab_addr = '0;
    unique case (va[VA_W-1:VA_W-2])
      2'b10: begin
        region   = RG_SYS;
        fcode    = (vpn_ext >= sys_len) ? FC_LENGTH : FC_NONE;
        tab_addr = sys_base_ext + vpn_bytes;
      end
      2'b00: begin
        if (!SYS_ONLY) begin
          region   = RG_P0;
          fcode    = (vpn_ext >= p0_len) ? FC_LENGTH : FC_NONE;
          tab_addr = p0_base + vpn_bytes;
        end
      end
      2'b01: begin
        if (!SYS_ONLY) begin
          region   = RG_P1;
          fcode    = (vpn_ext < p1_len) ? FC_LENGTH : FC_NONE;
          tab_addr = p1_base + vpn_bytes;
        end
      end
      default: begin
        region = RG_BAD;
        fcode  = FC_REGION;
      end
    endcase
  end
endmodule

// File: rtl/pgx_walker.sv
module pgx_walker
  import pgx_pkg::*;
#(
  parameter int PA_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic              map_enable,
  output logic [VA_W-1:0]   va_q,
  input  region_e           c_region,
  input  fault_e            c_fcode,
  input  logic [VA_W-1:0]   c_addr,
  input  fault_e            n_fcode,
  input  logic [VA_W-1:0]   n_addr,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output fault_e            rsp_fcode,
  output logic              rsp_nested,
  output logic [PROT_W-1:0] rsp_prot
);
  localparam int PFN_W = PA_W - OFF_W;

  walk_e            state;
  logic             men_q;
  logic [OFF_W-1:0] sva_off_q;
  logic             fire;

  assign req_ready = (state == ST_IDLE);
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      va_q       <= '0;
      men_q      <= 1'b0;
      sva_off_q  <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fcode  <= FC_NONE;
      rsp_nested <= 1'b0;
      rsp_prot   <= '0;
    end else begin
      mem_req   <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (fire) begin
            va_q  <= req_vaddr;
            men_q <= map_enable;
            state <= ST_CLASS;
          end
        end
        ST_CLASS: begin
          if (!men_q) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= va_q[PA_W-1:0];
            rsp_fcode  <= FC_NONE;
            rsp_nested <= 1'b0;
            rsp_prot   <= '0;
            state      <= ST_IDLE;
          end else if (c_fcode != FC_NONE) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= '0;
            rsp_fcode  <= c_fcode;
            rsp_nested <= 1'b0;
            rsp_prot   <= '0;
            state      <= ST_IDLE;
          end else if (c_region == RG_SYS) begin
            mem_req  <= 1'b1;
            mem_addr <= c_addr[PA_W-1:0];
            state    <= ST_WLEAF;
          end else begin
            sva_off_q <= c_addr[OFF_W-1:0];
            if (n_fcode != FC_NONE) begin
              rsp_valid  <= 1'b1;
              rsp_paddr  <= '0;
              rsp_fcode  <= n_fcode;
              rsp_nested <= 1'b1;
              rsp_prot   <= '0;
              state      <= ST_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= n_addr[PA_W-1:0];
              state    <= ST_WSYS;
            end
          end
        end
        ST_WSYS: begin
          if (mem_rvalid) begin
            if (!mem_rdata[VBIT]) begin
              rsp_valid  <= 1'b1;
              rsp_paddr  <= '0;
              rsp_fcode  <= FC_NOTVALID;
              rsp_nested <= 1'b1;
              rsp_prot   <= '0;
              state      <= ST_IDLE;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= {mem_rdata[PFN_W-1:0], sva_off_q};
              state    <= ST_WLEAF;
            end
          end
        end
        ST_WLEAF: begin
          if (mem_rvalid) begin
            rsp_valid  <= 1'b1;
            rsp_nested <= 1'b0;
            state      <= ST_IDLE;
            if (!mem_rdata[VBIT]) begin
              rsp_paddr <= '0;
              rsp_fcode <= FC_NOTVALID;
              rsp_prot  <= '0;
            end else begin
              rsp_paddr <= {mem_rdata[PFN_W-1:0], va_q[OFF_W-1:0]};
              rsp_fcode <= FC_NONE;
              rsp_prot  <= mem_rdata[PROT_HI:PROT_HI-PROT_W+1];
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  mem_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R8
  leaf_invalid_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WLEAF && mem_rvalid && !mem_rdata[VBIT]) |=>
      (rsp_valid && rsp_fcode == FC_NOTVALID && !rsp_nested));

  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> !req_ready);
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
#(
  parameter int PA_W  = 30,
  parameter int LEN_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic              map_enable,
  input  logic [PA_W-1:0]   sys_base,
  input  logic [LEN_W-1:0]  sys_len,
  input  logic [31:0]       p0_base,
  input  logic [LEN_W-1:0]  p0_len,
  input  logic [31:0]       p1_base,
  input  logic [LEN_W-1:0]  p1_len,
  output logic              mem_req,
  output logic [PA_W-1:0]   mem_addr,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              rsp_nested,
  output logic [3:0]        rsp_prot
);
  logic [VA_W-1:0] va_q;
  region_e         c_region;
  fault_e          c_fcode;
  logic [VA_W-1:0] c_addr;
  region_e         n_region;
  fault_e          n_fcode;
  logic [VA_W-1:0] n_addr;
  fault_e          fcode_w;

  pgx_region_check #(.PA_W(PA_W), .LEN_W(LEN_W), .SYS_ONLY(1'b0)) u_first (
    .va(va_q), .sys_base(sys_base), .sys_len(sys_len),
    .p0_base(p0_base), .p0_len(p0_len), .p1_base(p1_base), .p1_len(p1_len),
    .region(c_region), .fcode(c_fcode), .tab_addr(c_addr)
  );

  pgx_region_check #(.PA_W(PA_W), .LEN_W(LEN_W), .SYS_ONLY(1'b1)) u_nested (
    .va(c_addr), .sys_base(sys_base), .sys_len(sys_len),
    .p0_base(p0_base), .p0_len(p0_len), .p1_base(p1_base), .p1_len(p1_len),
    .region(n_region), .fcode(n_fcode), .tab_addr(n_addr)
  );

  pgx_walker #(.PA_W(PA_W)) u_walk (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .map_enable(map_enable), .va_q(va_q),
    .c_region(c_region), .c_fcode(c_fcode), .c_addr(c_addr),
    .n_fcode(n_fcode), .n_addr(n_addr),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fcode(fcode_w),
    .rsp_nested(rsp_nested), .rsp_prot(rsp_prot)
  );

  assign rsp_fault = fcode_w;

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R2
  bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !map_enable) |=> ##1
      (rsp_valid && rsp_fault == 2'd0 && rsp_paddr == $past(req_vaddr[PA_W-1:0], 2)));
endmodule

// File: tb/sim_pgx_translator.sv
module sim_pgx_translator;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W  = 30;
  localparam int LEN_W = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic map_enable = 1'b1;
  logic [PA_W-1:0] sys_base = '0;
  logic [LEN_W-1:0] sys_len = '0;
  logic [31:0] p0_base = '0;
  logic [LEN_W-1:0] p0_len = '0;
  logic [31:0] p1_base = '0;
  logic [LEN_W-1:0] p1_len = '0;
  logic mem_req;
  logic [PA_W-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic rsp_valid;
  logic [PA_W-1:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic rsp_nested;
  logic [3:0] rsp_prot;

  int n_chk = 0;
  int n_bad = 0;
  int rd_cnt = 0;
  logic [31:0] mem [int];

  always #(CLK_PERIOD/2) clk = ~clk;

  pgx_translator #(.PA_W(PA_W), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .map_enable(map_enable),
    .sys_base(sys_base), .sys_len(sys_len), .p0_base(p0_base), .p0_len(p0_len),
    .p1_base(p1_base), .p1_len(p1_len),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_nested(rsp_nested), .rsp_prot(rsp_prot)
  );

  function automatic logic [31:0] rd(input logic [31:0] pa);
    int key;
    key = int'(pa >> 2);
    if (mem.exists(key)) return mem[key];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= mem_req;
    mem_rdata  <= mem_req ? rd({2'b00, mem_addr}) : 32'h0;
    if (mem_req) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // behavioural model: returns expected response and clocks to response
  task automatic model(input logic [31:0] va, input bit men,
                       output logic [29:0] pa, output int fc, output bit nst,
                       output logic [3:0] prot, output int lat, output int reads);
    logic [31:0] pte, spte, sva;
    int vpn, svpn;
    pa = '0; fc = 0; nst = 0; prot = '0; lat = 1; reads = 0;
    if (!men) begin pa = va[29:0]; return; end
    vpn = int'(va[29:9]);
    if (va[31:30] == 2'b11) begin fc = 3; return; end
    if (va[31:30] == 2'b10) begin
      if (vpn >= int'(sys_len)) begin fc = 1; return; end
      pte = rd({2'b00, sys_base} + 32'(vpn * 4));
      lat = 3; reads = 1;
    end else begin
      if (va[30] == 1'b0 && vpn >= int'(p0_len)) begin fc = 1; return; end
      if (va[30] == 1'b1 && vpn <  int'(p1_len)) begin fc = 1; return; end
      sva = (va[30] ? p1_base : p0_base) + 32'(vpn * 4);
      if (sva[31:30] != 2'b10) begin fc = 3; nst = 1; return; end
      svpn = int'(sva[29:9]);
      if (svpn >= int'(sys_len)) begin fc = 1; nst = 1; return; end
      spte = rd({2'b00, sys_base} + 32'(svpn * 4));
      lat = 3; reads = 1;
      if (!spte[31]) begin fc = 2; nst = 1; return; end
      pte = rd({2'b00, spte[20:0], sva[8:0]});
      lat = 5; reads = 2;
    end
    if (!pte[31]) begin fc = 2; return; end
    pa = {pte[20:0], va[8:0]};
    prot = pte[30:27];
  endtask

  task automatic run(input logic [31:0] va, input bit men, input string tag);
    logic [29:0] e_pa; int e_fc; bit e_nst; logic [3:0] e_prot; int lat, e_rd, rd0;
    model(va, men, e_pa, e_fc, e_nst, e_prot, lat, e_rd);
    @(negedge clk);
    req_vaddr = va; map_enable = men; req_valid = 1'b1;
    rd0 = rd_cnt;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(rsp_valid == (k == lat), {tag, " R10 rsp_valid timing"}, 32'(rsp_valid), 32'(k == lat));
      if (k < lat) check(req_ready == 1'b0, {tag, " R10 busy"}, 32'(req_ready), 32'd0);
    end
    check(int'(rsp_fault) == e_fc, {tag, " fault"}, 32'(rsp_fault), 32'(e_fc));
    check(rsp_nested == e_nst, {tag, " R7 nested"}, 32'(rsp_nested), 32'(e_nst));
    if (e_fc == 0) begin
      check(rsp_paddr == e_pa, {tag, " R9 paddr"}, 32'(rsp_paddr), 32'(e_pa));
      if (men) check(rsp_prot == e_prot, {tag, " R9 prot"}, 32'(rsp_prot), 32'(e_prot));
    end
    check(rd_cnt - rd0 == e_rd, {tag, " R11 reads"}, 32'(rd_cnt - rd0), 32'(e_rd));
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0 && req_ready == 1'b1, {tag, " R10 pulse end"}, 32'({rsp_valid, req_ready}), 32'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    sys_base = 30'h0000_1000; sys_len = 22'd16;
    p0_base  = 32'h8000_0400; p0_len = 22'd8;
    p1_base  = 32'h7F80_0620; p1_len = 22'h1FFFF8;
    mem[int'(32'h1000 >> 2)]       = 32'h9800_0040; // sys page 0
    mem[int'(32'h1008 >> 2)]       = 32'h8000_0010; // sys page 2 -> 0x2000
    mem[int'(32'h100C >> 2)]       = 32'h8000_0018; // sys page 3 -> 0x3000
    mem[int'(32'h103C >> 2)]       = 32'hF800_00AB; // sys page 15
    mem[int'(32'h2000 >> 2)]       = 32'h8800_0123; // p0 page 0
    mem[int'(32'h200C >> 2)]       = 32'h0000_0055; // p0 page 3 invalid
    mem[int'(32'h201C >> 2)]       = 32'h8000_0200; // p0 page 7
    mem[int'(32'h3000 >> 2)]       = 32'hA000_0777; // p1 page 0x1FFFF8
    mem[int'(32'h301C >> 2)]       = 32'h8000_0100; // p1 page 0x1FFFFF
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);

    run(32'hC123_4567, 1'b0, "R2 bypass");
    run(32'h0000_0034, 1'b0, "R2 bypass low");
    run(32'hC000_0000, 1'b1, "R3 bad region");
    run(32'h8000_0123, 1'b1, "R6 sys page 0");
    run(32'h8000_1E44, 1'b1, "R4 sys last page");
    run(32'h8000_2000, 1'b1, "R4 sys length");
    run(32'h8000_0A00, 1'b1, "R8 sys invalid");
    run(32'h0000_0034, 1'b1, "R7 p0 page 0");
    run(32'h0000_0FFF, 1'b1, "R4 p0 last page");
    run(32'h0000_1000, 1'b1, "R4 p0 length");
    run(32'h0000_0600, 1'b1, "R8 p0 invalid");
    run(32'h7FFF_F05A, 1'b1, "R5 p1 first page");
    run(32'h7FFF_FFFF, 1'b1, "R5 p1 top page");
    run(32'h7FFF_EE00, 1'b1, "R5 p1 length");
    p0_base = 32'h8000_0800;
    run(32'h0000_0010, 1'b1, "R7 nested invalid");
    p0_base = 32'h8000_4000;
    run(32'h0000_0010, 1'b1, "R7 nested length");
    p0_base = 32'h0000_0400;
    run(32'h0000_0010, 1'b1, "R7 nested region");
    p0_base = 32'h8000_0400;
    run(32'h0000_0E00, 1'b1, "R9 p0 after restore");
    summary();
    $finish;
  end
endmodule